// File: doc/BRIEF.md
# Retirement Record Byte Serializer

This block takes one retirement record per executed instruction and turns it into a fixed-length 88-byte packet on a byte-wide stream. The record arrives in parallel on a valid/ready handshake. At the moment of capture the block cleans up the fields that a retiring pipeline may leave undefined. Register data tied to index zero becomes zero. The destination index becomes zero when no register is written. The memory address and byte masks become zero when no memory access took place.

After capture, the packet leaves one byte per accepted transfer on a valid/ready byte output. All multi-byte fields are sent least significant byte first. The block holds exactly one record. The input side stays closed until the last byte of the current packet has been taken, so a downstream consumer can frame packets by counting bytes alone.

Top module: `trc_exec_serializer`

## Requirements
- R1: Each accepted record produces exactly 88 output bytes. The 64-bit fields occupy eight bytes each, least significant byte first, in this order: retired-instruction count (bytes 0-7), PC before (8-15), PC after (16-23), instruction word (24-31), rs1 value (32-39), rs2 value (40-47), rd write value (48-55), memory address (56-63), memory read data (64-71), memory write data (72-79).
- R2: The 32-bit instruction word fills bytes 24-27 and is zero-extended, so bytes 28-31 are 0x00.
- R3: Bytes 80-84 carry, in order, the read mask, the write mask, the rs1 index, the rs2 index and the rd index, each register index zero-extended to a byte.
- R4: Bytes 85, 86 and 87 carry the trap, halt and interrupt flags, each sent as 0x00 or 0x01.
- R5: When `rd_wen` is 0, byte 84 is 0x00 and bytes 48-55 are 0x00, whatever values are on `rd_idx` and `rd_val`.
- R6: When the rd index is zero, bytes 48-55 are 0x00 even if `rd_wen` is 1.
- R7: When `rs1_idx` (or `rs2_idx`) is zero, bytes 32-39 (or 40-47) are 0x00, whatever value is on the data input.
- R8: When `mem_en` is 0, bytes 56-63, byte 80 and byte 81 are 0x00. The memory read and write data bytes 64-79 pass through unchanged.
- R9: `rec_ready` is low from the cycle after a record is accepted until byte 87 is accepted. In the following cycle it is high and `out_valid` is low.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_byte` holds its value.
- R11: After reset, `rec_ready` is high and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_valid | input | 1 | Record present |
| rec_ready | output | 1 | Record can be accepted |
| order | input | 64 | Retired-instruction count after this instruction |
| pc_before | input | 64 | PC of the instruction |
| pc_after | input | 64 | Next PC |
| insn | input | 32 | Instruction word |
| rs1_idx | input | 5 | First source register index |
| rs1_val | input | 64 | First source register value |
| rs2_idx | input | 5 | Second source register index |
| rs2_val | input | 64 | Second source register value |
| rd_wen | input | 1 | A register is written |
| rd_idx | input | 5 | Destination register index |
| rd_val | input | 64 | Destination write value |
| mem_en | input | 1 | A memory access took place |
| mem_addr | input | 64 | Memory byte address |
| mem_rdata | input | 64 | Memory read data |
| mem_wdata | input | 64 | Memory write data |
| mem_rmask | input | 8 | Bytes read |
| mem_wmask | input | 8 | Bytes written |
| trap | input | 1 | Trap flag |
| halt | input | 1 | Halt flag |
| intr | input | 1 | First instruction of a trap handler |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Consumer takes the byte |
| out_byte | output | 8 | Packet byte |

## Verification
The hardest case to reach from the ports is a stall in the middle of a packet while the next record is already waiting at the input. At that point the hold rule and the closed input must both apply at once. The stimulus presents back-to-back records while a pseudo-random pattern drops `out_ready`. This leaves records pending on `rec_valid` through stalls at arbitrary byte positions. Each normalization case is driven with deliberately non-zero junk on the field that must be suppressed, so that a missing zeroing rule shows up as a wrong byte.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int unsigned XLEN      = 64;
  localparam int unsigned ILEN      = 32;
  localparam int unsigned REGW      = 5;
  localparam int unsigned WIDE_CNT  = 10;
  localparam int unsigned NARROW_CNT = 8;
  localparam int unsigned FRAME_BYTES = WIDE_CNT * (XLEN / 8) + NARROW_CNT;
  localparam int unsigned FRAME_W   = FRAME_BYTES * 8;
  localparam int unsigned FLAG_CNT  = 3;
endpackage

// File: rtl/trc_rst_sync.sv
module trc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/trc_normalize.sv
module trc_normalize
  import trc_pkg::*;
#(
  parameter int unsigned W  = XLEN,
  parameter int unsigned IW = ILEN,
  parameter int unsigned RW = REGW,
  localparam int unsigned FW = WIDE_CNT * W + NARROW_CNT * 8
) (
  input  logic [W-1:0]  order,
  input  logic [W-1:0]  pc_before,
  input  logic [W-1:0]  pc_after,
  input  logic [IW-1:0] insn,
  input  logic [RW-1:0] rs1_idx,
  input  logic [W-1:0]  rs1_val,
  input  logic [RW-1:0] rs2_idx,
  input  logic [W-1:0]  rs2_val,
  input  logic          rd_wen,
  input  logic [RW-1:0] rd_idx,
  input  logic [W-1:0]  rd_val,
  input  logic          mem_en,
  input  logic [W-1:0]  mem_addr,
  input  logic [W-1:0]  mem_rdata,
  input  logic [W-1:0]  mem_wdata,
  input  logic [7:0]    mem_rmask,
  input  logic [7:0]    mem_wmask,
  input  logic          trap,
  input  logic          halt,
  input  logic          intr,
  output logic [FW-1:0] frame
);
  logic [7:0]   rs1_b, rs2_b, rd_b;
  logic [W-1:0] rs1_n, rs2_n, rd_n, addr_n, insn_w;
  logic [7:0]   rmask_n, wmask_n;

  always_comb begin
    rs1_b   = 8'(rs1_idx);
    rs2_b   = 8'(rs2_idx);
    rd_b    = rd_wen ? 8'(rd_idx) : 8'h00;
    rs1_n   = (rs1_b == 8'h00) ? '0 : rs1_val;
    rs2_n   = (rs2_b == 8'h00) ? '0 : rs2_val;
    rd_n    = (rd_b == 8'h00)  ? '0 : rd_val;
    addr_n  = mem_en ? mem_addr  : '0;
    rmask_n = mem_en ? mem_rmask : 8'h00;
    wmask_n = mem_en ? mem_wmask : 8'h00;
    insn_w  = W'(insn);
    // Lowest byte of the frame leaves first.
    frame = {7'b0, intr, 7'b0, halt, 7'b0, trap,
             rd_b, rs2_b, rs1_b, wmask_n, rmask_n,
             mem_wdata, mem_rdata, addr_n, rd_n, rs2_n, rs1_n,
             insn_w, pc_after, pc_before, order};
  end
endmodule

// File: rtl/trc_byte_sender.sv
module trc_byte_sender
  import trc_pkg::*;
#(
  parameter int unsigned NBYTES = FRAME_BYTES,
  parameter int unsigned NFLAGS = FLAG_CNT,
  localparam int unsigned IDX_W = $clog2(NBYTES),
  localparam int unsigned FW    = NBYTES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] frame_in,
  output logic          busy,
  input  logic          out_ready,
  output logic [7:0]    out_byte
);
  localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(NBYTES - 1);
  localparam logic [IDX_W-1:0] FLAG_FIRST = IDX_W'(NBYTES - NFLAGS);

  logic [FW-1:0]    frame_q;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             busy_q, busy_d;
  logic             fire, at_last;

  always_comb begin
    fire    = busy_q && out_ready;
    at_last = (idx_q == LAST_IDX);
    busy_d  = busy_q;
    idx_d   = idx_q;
    if (load) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (fire) begin
      busy_d = !at_last;
      idx_d  = at_last ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) frame_q <= frame_in;
  end

  assign busy     = busy_q;
  assign out_byte = frame_q[int'(idx_q) * 8 +: 8];

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy_q && (idx_q == '0)) else $error("start");  // R1

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !out_ready |=> busy_q && $stable(out_byte)) else $error("hold");  // R10

  AST_RELEASE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && out_ready && (idx_q == LAST_IDX) |=> !busy_q) else $error("release");  // R9

  AST_FLAG_IS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && (idx_q >= FLAG_FIRST) |-> (out_byte[7:1] == 7'd0)) else $error("flag");  // R4
endmodule

// File: rtl/trc_exec_serializer.sv
module trc_exec_serializer
  import trc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_valid,
  output logic              rec_ready,
  input  logic [XLEN-1:0]   order,
  input  logic [XLEN-1:0]   pc_before,
  input  logic [XLEN-1:0]   pc_after,
  input  logic [ILEN-1:0]   insn,
  input  logic [REGW-1:0]   rs1_idx,
  input  logic [XLEN-1:0]   rs1_val,
  input  logic [REGW-1:0]   rs2_idx,
  input  logic [XLEN-1:0]   rs2_val,
  input  logic              rd_wen,
  input  logic [REGW-1:0]   rd_idx,
  input  logic [XLEN-1:0]   rd_val,
  input  logic              mem_en,
  input  logic [XLEN-1:0]   mem_addr,
  input  logic [XLEN-1:0]   mem_rdata,
  input  logic [XLEN-1:0]   mem_wdata,
  input  logic [7:0]        mem_rmask,
  input  logic [7:0]        mem_wmask,
  input  logic              trap,
  input  logic              halt,
  input  logic              intr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_byte
);
  logic               rst_n_q;
  logic [FRAME_W-1:0] frame;
  logic               busy, load;

  trc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_q));

  trc_normalize #(.W(XLEN), .IW(ILEN), .RW(REGW)) u_norm (
    .order(order), .pc_before(pc_before), .pc_after(pc_after), .insn(insn),
    .rs1_idx(rs1_idx), .rs1_val(rs1_val), .rs2_idx(rs2_idx), .rs2_val(rs2_val),
    .rd_wen(rd_wen), .rd_idx(rd_idx), .rd_val(rd_val),
    .mem_en(mem_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_rmask(mem_rmask), .mem_wmask(mem_wmask),
    .trap(trap), .halt(halt), .intr(intr), .frame(frame)
  );

  assign rec_ready = !busy;
  assign load      = rec_valid && rec_ready;
  assign out_valid = busy;

  trc_byte_sender #(.NBYTES(FRAME_BYTES), .NFLAGS(FLAG_CNT)) u_send (
    .clk(clk), .rst_n(rst_n_q), .load(load), .frame_in(frame),
    .busy(busy), .out_ready(out_ready), .out_byte(out_byte)
  );

  AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n_q)
    rec_valid && rec_ready |=> out_valid && !rec_ready) else $error("accept");  // R9
endmodule

// File: tb/trc_exec_serializer_tb.sv
module trc_exec_serializer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 88;

  logic clk = 1'b0;
  logic rst_n;
  logic rec_valid, rec_ready;
  logic [63:0] order, pc_before, pc_after, rs1_val, rs2_val, rd_val;
  logic [63:0] mem_addr, mem_rdata, mem_wdata;
  logic [31:0] insn;
  logic [4:0]  rs1_idx, rs2_idx, rd_idx;
  logic        rd_wen, mem_en, trap, halt, intr;
  logic [7:0]  mem_rmask, mem_wmask;
  logic        out_valid, out_ready, out_byte_dummy;
  logic [7:0]  out_byte;

  always #(CLK_PERIOD/2) clk = ~clk;

  trc_exec_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .order(order), .pc_before(pc_before), .pc_after(pc_after), .insn(insn),
    .rs1_idx(rs1_idx), .rs1_val(rs1_val), .rs2_idx(rs2_idx), .rs2_val(rs2_val),
    .rd_wen(rd_wen), .rd_idx(rd_idx), .rd_val(rd_val), .mem_en(mem_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
    .mem_rmask(mem_rmask), .mem_wmask(mem_wmask), .trap(trap), .halt(halt),
    .intr(intr), .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte)
  );

  int n_checks = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  int         pos_q[$];
  logic       bp_mode = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic       run_done = 1'b0;
  logic       finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Expected packet, built from the requirements.
  task automatic push_expected(input string tag);
    logic [7:0] b[NB];
    logic [63:0] w[10];
    logic [7:0] rdb;
    rdb  = rd_wen ? {3'b0, rd_idx} : 8'h00;
    w[0] = order;
    w[1] = pc_before;
    w[2] = pc_after;
    w[3] = {32'h0, insn};
    w[4] = (rs1_idx == 0) ? 64'h0 : rs1_val;
    w[5] = (rs2_idx == 0) ? 64'h0 : rs2_val;
    w[6] = (rdb == 0) ? 64'h0 : rd_val;
    w[7] = mem_en ? mem_addr : 64'h0;
    w[8] = mem_rdata;
    w[9] = mem_wdata;
    for (int f = 0; f < 10; f++)
      for (int k = 0; k < 8; k++) b[f*8+k] = w[f][k*8 +: 8];
    b[80] = mem_en ? mem_rmask : 8'h00;
    b[81] = mem_en ? mem_wmask : 8'h00;
    b[82] = {3'b0, rs1_idx};
    b[83] = {3'b0, rs2_idx};
    b[84] = rdb;
    b[85] = {7'b0, trap};
    b[86] = {7'b0, halt};
    b[87] = {7'b0, intr};
    for (int i = 0; i < NB; i++) begin
      exp_q.push_back(b[i]);
      pos_q.push_back(i);
      if (i >= 85)                tag_q.push_back({tag, " R4"});
      else if (i >= 28 && i < 32) tag_q.push_back({tag, " R2"});
      else if (i >= 80)           tag_q.push_back({tag, " R3"});
      else                        tag_q.push_back(tag);
    end
  endtask

  task automatic send_rec(input string tag);
    rec_valid = 1'b1;
    while (!rec_ready) @(negedge clk);
    push_expected(tag);
    @(negedge clk);
    rec_valid = 1'b0;
  endtask

  task automatic base_fields(input logic [63:0] seed);
    order = seed ^ 64'h0102_0304_0506_0708;  pc_before = 64'h8000_0000_0000_1000 + seed;
    pc_after = pc_before + 4;  insn = 32'hDEAD_BEEF ^ seed[31:0];
    rs1_idx = 5'd3;  rs1_val = 64'h1111_2222_3333_4444 ^ seed;
    rs2_idx = 5'd17; rs2_val = 64'h5555_6666_7777_8888 ^ seed;
    rd_wen = 1'b1;   rd_idx = 5'd31; rd_val = 64'h99AA_BBCC_DDEE_FF00 ^ seed;
    mem_en = 1'b1;   mem_addr = 64'h8000_0000_0000_0040 + seed;
    mem_rdata = 64'hCAFE_F00D_1234_5678 ^ seed; mem_wdata = 64'h0BAD_C0DE_8765_4321 ^ seed;
    mem_rmask = 8'h0F; mem_wmask = 8'hF0; trap = 1'b0; halt = 1'b0; intr = 1'b0;
  endtask

  // Monitor: sets out_ready, then checks what the next edge will take.
  logic       prev_stall = 1'b0;
  logic [7:0] prev_byte;
  logic       after_last = 1'b0;
  int         pkt_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = bp_mode ? (lfsr[0] | lfsr[2]) : 1'b1;
      if (after_last) begin
        check(rec_ready === 1'b1 && out_valid === 1'b0, "R9", "ready/valid after last byte",
              {62'h0, rec_ready, out_valid}, 64'h2);
        after_last = 1'b0;
      end
      if (prev_stall) begin
        check(out_valid === 1'b1 && out_byte === prev_byte, "R10", "byte held under stall",
              {55'h0, out_valid, out_byte}, {55'h0, 1'b1, prev_byte});
      end
      if (out_valid) check(rec_ready === 1'b0, "R9", "ready low while sending",
                           {63'h0, rec_ready}, 64'h0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "unexpected extra byte", {56'h0, out_byte}, 64'h0);
        end else begin
          logic [7:0] e; string t; int p;
          e = exp_q.pop_front(); t = tag_q.pop_front(); p = pos_q.pop_front();
          check(out_byte === e, t, $sformatf("byte %0d", p), {56'h0, out_byte}, {56'h0, e});
          if (p == NB - 1) begin after_last = 1'b1; pkt_cnt++; end
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_byte  = out_byte;
    end
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!run_done) check(1'b0, "R1", "watchdog expired", 64'h0, 64'h1);
    finish_up();
  end

  initial begin
    rst_n = 1'b0; rec_valid = 1'b0; out_ready = 1'b1;
    base_fields(64'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(rec_ready === 1'b1 && out_valid === 1'b0, "R11", "state after reset",
          {62'h0, rec_ready, out_valid}, 64'h2);

    base_fields(64'h0);                   send_rec("R1 full record");
    base_fields(64'h77); order = 64'h8877_6655_4433_2211; send_rec("R1 order LSB first");
    base_fields(64'h13); rd_wen = 1'b0;   send_rec("R5 no rd write");
    base_fields(64'h29); rd_idx = 5'd0;   send_rec("R6 rd index zero");
    base_fields(64'h31); rs1_idx = 5'd0;  send_rec("R7 rs1 index zero");
    base_fields(64'h45); rs2_idx = 5'd0;  send_rec("R7 rs2 index zero");
    base_fields(64'h52); mem_en = 1'b0;   send_rec("R8 no memory access");
    base_fields(64'h63); trap = 1'b1; halt = 1'b1; intr = 1'b1; send_rec("R4 flags set");
    bp_mode = 1'b1;
    for (int r = 0; r < 6; r++) begin
      base_fields(64'h100 * r + 7);
      rd_wen = r[0]; mem_en = r[1]; rs1_idx = 5'(r); trap = r[2]; intr = r[0];
      send_rec("R10 backpressure");
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(pkt_cnt == 14, "R1", "packets completed", 64'(pkt_cnt), 64'd14);
    run_done = 1'b1;
    finish_up();
  end

  assign out_byte_dummy = 1'b0;
endmodule